// File: doc/BRIEF.md
# Programmable I/O Sequencer Core

This block is a small programmable engine for bit-level I/O work. It fetches 16-bit instructions from a 32-word instruction store and runs one instruction per clock. Control flow comes from a program counter that loops back on its own, a conditional jump, a wait on a pin or an event flag, a load of a small constant, and a no-operation. Every instruction also carries a 5-bit field. That field is split into a value for a few dedicated side pins and an idle count that runs after the instruction.

A host fills the instruction store through a simple synchronous write port, normally while it holds the stall input high. Shift registers, FIFOs and the event-flag bank are outside this block. The core only sees a "shift register drained" status and the current flag values as inputs. Two scratch registers, X and Y, are brought out as outputs, as are the GPIO output and direction banks, the side pins and the program counter.

The wrap window is set by two address inputs, the loop start and the loop end. The host drives these with 0 and the last address unless it needs a tighter loop.

Top module: `ioseq_core`

## Requirements
- R1: While reset is asserted, pc, xReg, yReg, gpioOut, gpioDir and sidePins are all zero, and retire is low while stall is high.
- R2: An instruction that completes with no jump taken moves pc to pc+1. The exception is pc equal to wrapTop, where the next fetch is from wrapTarget in the very next cycle, with no extra cycle.
- R3: Instruction bits [15:13] hold the opcode: 000 jump, 001 wait, 111 set, 101 move. For a jump, bits [7:5] hold the condition and bits [4:0] the target. Condition 000 always jumps, and a taken jump overrides the wrap at wrapTop.
- R4: Jump conditions: 001 X is zero, 011 Y is zero, 101 X differs from Y, 110 gpioIn[jmpPinSel] is high, 111 osrEmpty is low. When the condition is false, the core falls through to the next address.
- R5: Conditions 010 and 100 jump when X (resp. Y) is non-zero before the update. They decrement the register by one whether or not the jump is taken, so 0 becomes 32'hFFFFFFFF.
- R6: A wait (bit 7 polarity, bits [6:5] source, bits [4:0] index) holds pc until the selected bit equals the polarity. Source 00 is gpioIn[index], 01 is gpioIn[(inBase+index) mod 32], and 10 is irqFlags[index mod 8].
- R7: A set writes the 5-bit immediate in bits [4:0]. Destination bits [7:5] = 000 writes gpioOut bits (setBase+i) mod 32 for i=0..4, 100 writes gpioDir in the same way, 001 writes X and 010 writes Y (zero-extended).
- R8: The move Y-to-Y word 16'hA042, and every opcode other than jump, wait and set, completes in one cycle and changes no register or output apart from pc and sidePins.
- R9: Bits [12:8] form the side/delay field. Its top SIDE_W bits (default 2) are the side value, and the low 5-SIDE_W bits give N idle cycles after the instruction completes. During those cycles pc, sidePins and the registers hold, and the next instruction executes N+1 cycles after the previous one.
- R10: The side value is driven on sidePins from the first cycle an instruction issues, including while a wait holds it. The idle count starts only when the wait completes.
- R11: While stall is high, pc, the idle count, X, Y, gpioOut, gpioDir and sidePins all hold their values.
- R12: retire is high exactly in cycles where an instruction completes, so never during idle cycles, an unmet wait or a stall.
- R13: With progWe high at a clock edge, progData is stored at progAddr and is what the core later executes from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes execution while high |
| progWe | input | 1 | Instruction store write enable |
| progAddr | input | ADDR_W | Instruction store write address |
| progData | input | 16 | Instruction store write data |
| wrapTarget | input | ADDR_W | Loop start address |
| wrapTop | input | ADDR_W | Loop end address |
| inBase | input | 5 | Base for relative pin waits |
| setBase | input | 5 | First GPIO bit written by a set |
| jmpPinSel | input | 5 | GPIO bit tested by the pin jump |
| gpioIn | input | 32 | GPIO input levels |
| irqFlags | input | 8 | Event flag values |
| osrEmpty | input | 1 | Output shift register has reached its threshold |
| pc | output | ADDR_W | Program counter |
| retire | output | 1 | An instruction completes this cycle |
| xReg | output | 32 | X scratch register |
| yReg | output | 32 | Y scratch register |
| gpioOut | output | 32 | GPIO output levels |
| gpioDir | output | 32 | GPIO direction bits |
| sidePins | output | SIDE_W | Side pin levels |

## Verification
Since pc is a port, a wrong wrap, branch or idle count shows up at the sample right after the edge where the instruction completes. A decrement that goes wrong or is skipped only becomes visible on xReg or yReg, again one cycle later. However, a wrong condition flag derived from those registers can stay hidden until a jump tests it. For that reason every jump condition is run with both outcomes, and pc and the registers are checked together. A side value driven late, or an idle count that starts while a wait is still holding, appears on sidePins and pc only around the cycle where the wait releases, so those windows are sampled cycle by cycle.

// File: rtl/ioseq_pkg.sv
package ioseq_pkg;
  localparam int GPIO_W  = 32;
  localparam int IRQ_N   = 8;
  localparam int INSTR_W = 16;
  localparam int IMM_W   = 5;

  localparam logic [2:0] OP_JMP  = 3'd0;
  localparam logic [2:0] OP_WAIT = 3'd1;
  localparam logic [2:0] OP_SET  = 3'd7;

  localparam logic [2:0] JC_ALWAYS = 3'd0;
  localparam logic [2:0] JC_XZERO  = 3'd1;
  localparam logic [2:0] JC_XDEC   = 3'd2;
  localparam logic [2:0] JC_YZERO  = 3'd3;
  localparam logic [2:0] JC_YDEC   = 3'd4;
  localparam logic [2:0] JC_XNEY   = 3'd5;
  localparam logic [2:0] JC_PIN    = 3'd6;
  localparam logic [2:0] JC_OSRLEFT = 3'd7;

  localparam logic [1:0] WS_GPIO = 2'd0;
  localparam logic [1:0] WS_REL  = 2'd1;
  localparam logic [1:0] WS_IRQ  = 2'd2;

  localparam logic [2:0] SD_PINS = 3'd0;
  localparam logic [2:0] SD_X    = 3'd1;
  localparam logic [2:0] SD_Y    = 3'd2;
  localparam logic [2:0] SD_DIRS = 3'd4;

  typedef struct packed {
    logic             setX;
    logic             setY;
    logic             decX;
    logic             decY;
    logic             setPins;
    logic             setDirs;
    logic             setSide;
    logic [IMM_W-1:0] imm;
    logic [IMM_W-1:0] side;
  } dpStrobe_t;

  function automatic logic [GPIO_W-1:0] rotl(input logic [GPIO_W-1:0] v,
                                             input logic [4:0] s);
    logic [2*GPIO_W-1:0] d;
    d = {v, v} << s;
    return d[2*GPIO_W-1:GPIO_W];
  endfunction
endpackage

// File: rtl/ioseq_imem.sv
module ioseq_imem #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             wAddr,
  input  logic [ioseq_pkg::INSTR_W-1:0] wData,
  input  logic [ADDR_W-1:0]             rAddr,
  output logic [ioseq_pkg::INSTR_W-1:0] rData
);
  logic [ioseq_pkg::INSTR_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wAddr] <= wData;
  end

  assign rData = store[rAddr];
endmodule

// File: rtl/ioseq_ctrl.sv
module ioseq_ctrl
  import ioseq_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  parameter int SIDE_W     = 2,
  localparam int ADDR_W    = $clog2(PROG_DEPTH),
  localparam int DLY_W     = IMM_W - SIDE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  wrapTarget,
  input  logic [ADDR_W-1:0]  wrapTop,
  input  logic [4:0]         inBase,
  input  logic [4:0]         jmpPinSel,
  input  logic [GPIO_W-1:0]  gpioIn,
  input  logic [IRQ_N-1:0]   irqFlags,
  input  logic               osrEmpty,
  input  logic               xZero,
  input  logic               yZero,
  input  logic               xNeY,
  output logic [ADDR_W-1:0]  pc,
  output logic               retire,
  output logic               jmpTaken,
  output logic               delayBusy,
  output dpStrobe_t          stb
);
  logic [ADDR_W-1:0] pcQ;
  logic [DLY_W-1:0]  dlyQ;
  logic [2:0]        opcode;
  logic [IMM_W-1:0]  field;
  logic [7:0]        operand;
  logic              active;
  logic              condTrue;
  logic              waitBit;
  logic              waitMet;
  logic              done;
  logic [4:0]        relIdx;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] nextPc;

  assign opcode  = instr[15:13];
  assign field   = instr[12:8];
  assign operand = instr[7:0];

  assign delayBusy = (dlyQ != '0);
  assign active    = !stall && !delayBusy;

  always_comb begin
    unique case (operand[7:5])
      JC_ALWAYS:  condTrue = 1'b1;
      JC_XZERO:   condTrue = xZero;
      JC_XDEC:    condTrue = !xZero;
      JC_YZERO:   condTrue = yZero;
      JC_YDEC:    condTrue = !yZero;
      JC_XNEY:    condTrue = xNeY;
      JC_PIN:     condTrue = gpioIn[jmpPinSel];
      JC_OSRLEFT: condTrue = !osrEmpty;
      default:    condTrue = 1'b0;
    endcase
  end

  assign relIdx = inBase + operand[4:0];

  always_comb begin
    unique case (operand[6:5])
      WS_GPIO: waitBit = gpioIn[operand[4:0]];
      WS_REL:  waitBit = gpioIn[relIdx];
      WS_IRQ:  waitBit = irqFlags[operand[2:0]];
      default: waitBit = operand[7];
    endcase
  end

  assign waitMet  = (waitBit == operand[7]);
  assign done     = active && ((opcode != OP_WAIT) || waitMet);
  assign jmpTaken = done && (opcode == OP_JMP) && condTrue;
  assign seqPc    = (pcQ == wrapTop) ? wrapTarget : pcQ + ADDR_W'(1);
  assign nextPc   = jmpTaken ? operand[ADDR_W-1:0] : seqPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      dlyQ <= '0;
    end else if (done) begin
      pcQ  <= nextPc;
      dlyQ <= field[DLY_W-1:0];
    end else if (!stall && delayBusy) begin
      dlyQ <= dlyQ - DLY_W'(1);
    end
  end

  always_comb begin
    stb         = '0;
    stb.setSide = active;
    stb.side    = field >> DLY_W;
    stb.imm     = operand[4:0];
    if (done) begin
      case (opcode)
        OP_JMP: begin
          stb.decX = (operand[7:5] == JC_XDEC);
          stb.decY = (operand[7:5] == JC_YDEC);
        end
        OP_SET: begin
          case (operand[7:5])
            SD_PINS: stb.setPins = 1'b1;
            SD_DIRS: stb.setDirs = 1'b1;
            SD_X:    stb.setX    = 1'b1;
            SD_Y:    stb.setY    = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign pc     = pcQ;
  assign retire = done;
endmodule

// File: rtl/ioseq_dpath.sv
module ioseq_dpath
  import ioseq_pkg::*;
#(
  parameter int SIDE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [4:0]        setBase,
  output logic [GPIO_W-1:0] xReg,
  output logic [GPIO_W-1:0] yReg,
  output logic [GPIO_W-1:0] gpioOut,
  output logic [GPIO_W-1:0] gpioDir,
  output logic [SIDE_W-1:0] sidePins,
  output logic              xZero,
  output logic              yZero,
  output logic              xNeY
);
  logic [GPIO_W-1:0] xQ, yQ, outQ, dirQ;
  logic [SIDE_W-1:0] sideQ;
  logic [GPIO_W-1:0] laneMask, laneData, immWide;
  logic              unusedSideBits;

  assign immWide  = GPIO_W'(stb.imm);
  assign laneMask = rotl(GPIO_W'({IMM_W{1'b1}}), setBase);
  assign laneData = rotl(immWide, setBase);
  assign unusedSideBits = ^stb.side[IMM_W-1:SIDE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xQ    <= '0;
      yQ    <= '0;
      outQ  <= '0;
      dirQ  <= '0;
      sideQ <= '0;
    end else begin
      if (stb.setX)      xQ <= immWide;
      else if (stb.decX) xQ <= xQ - GPIO_W'(1);
      if (stb.setY)      yQ <= immWide;
      else if (stb.decY) yQ <= yQ - GPIO_W'(1);
      if (stb.setPins)   outQ <= (outQ & ~laneMask) | (laneData & laneMask);
      if (stb.setDirs)   dirQ <= (dirQ & ~laneMask) | (laneData & laneMask);
      if (stb.setSide)   sideQ <= stb.side[SIDE_W-1:0];
    end
  end

  assign xZero    = (xQ == '0);
  assign yZero    = (yQ == '0);
  assign xNeY     = (xQ != yQ);
  assign xReg     = xQ;
  assign yReg     = yQ;
  assign gpioOut  = outQ;
  assign gpioDir  = dirQ;
  assign sidePins = sideQ;
endmodule

// File: rtl/ioseq_core.sv
module ioseq_core
  import ioseq_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  parameter int SIDE_W     = 2,
  localparam int ADDR_W    = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic               progWe,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic [ADDR_W-1:0]  wrapTarget,
  input  logic [ADDR_W-1:0]  wrapTop,
  input  logic [4:0]         inBase,
  input  logic [4:0]         setBase,
  input  logic [4:0]         jmpPinSel,
  input  logic [GPIO_W-1:0]  gpioIn,
  input  logic [IRQ_N-1:0]   irqFlags,
  input  logic               osrEmpty,
  output logic [ADDR_W-1:0]  pc,
  output logic               retire,
  output logic [GPIO_W-1:0]  xReg,
  output logic [GPIO_W-1:0]  yReg,
  output logic [GPIO_W-1:0]  gpioOut,
  output logic [GPIO_W-1:0]  gpioDir,
  output logic [SIDE_W-1:0]  sidePins
);
  logic [INSTR_W-1:0] curInstr;
  logic               jmpTaken;
  logic               delayBusy;
  logic               xZero, yZero, xNeY;
  dpStrobe_t          stb;

  ioseq_imem #(.DEPTH(PROG_DEPTH), .ADDR_W(ADDR_W)) u_imem (
    .clk(clk), .we(progWe), .wAddr(progAddr), .wData(progData),
    .rAddr(pc), .rData(curInstr)
  );

  ioseq_ctrl #(.PROG_DEPTH(PROG_DEPTH), .SIDE_W(SIDE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .instr(curInstr),
    .wrapTarget(wrapTarget), .wrapTop(wrapTop), .inBase(inBase),
    .jmpPinSel(jmpPinSel), .gpioIn(gpioIn), .irqFlags(irqFlags),
    .osrEmpty(osrEmpty), .xZero(xZero), .yZero(yZero), .xNeY(xNeY),
    .pc(pc), .retire(retire), .jmpTaken(jmpTaken),
    .delayBusy(delayBusy), .stb(stb)
  );

  ioseq_dpath #(.SIDE_W(SIDE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .setBase(setBase),
    .xReg(xReg), .yReg(yReg), .gpioOut(gpioOut), .gpioDir(gpioDir),
    .sidePins(sidePins), .xZero(xZero), .yZero(yZero), .xNeY(xNeY)
  );
endmodule

// File: rtl/ioseq_checker.sv
module ioseq_checker #(
  parameter int ADDR_W = 5,
  parameter int SIDE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input logic [ADDR_W-1:0] pc,
  input logic              retire,
  input logic [31:0]       xReg,
  input logic [SIDE_W-1:0] sidePins,
  input logic [ADDR_W-1:0] wrapTarget,
  input logic [ADDR_W-1:0] wrapTop,
  input logic [2:0]        opField,
  input logic [2:0]        condField,
  input logic [SIDE_W-1:0] sideField,
  input logic              jmpTaken,
  input logic              delayBusy
);
  a_r2_zero_cycle_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !jmpTaken && pc == wrapTop) |=> (pc == $past(wrapTarget)));

  a_r5_post_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (retire && opField == 3'd0 && condField == 3'd2) |=> (xReg == $past(xReg) - 32'd1));

  a_r9_no_retire_while_idle: assert property (@(posedge clk) disable iff (!rstN)
    delayBusy |-> !retire);

  a_r10_side_on_issue: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !delayBusy) |=> (sidePins == $past(sideField)));

  a_r11_stall_freezes: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(pc) && $stable(xReg) && $stable(sidePins)));

  a_r12_pc_moves_on_retire: assert property (@(posedge clk) disable iff (!rstN)
    !retire |=> $stable(pc));
endmodule

bind ioseq_core ioseq_checker #(.ADDR_W(ADDR_W), .SIDE_W(SIDE_W)) u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .pc(pc), .retire(retire),
  .xReg(xReg), .sidePins(sidePins), .wrapTarget(wrapTarget), .wrapTop(wrapTop),
  .opField(curInstr[15:13]), .condField(curInstr[7:5]),
  .sideField(curInstr[12 -: SIDE_W]), .jmpTaken(jmpTaken), .delayBusy(delayBusy)
);

// File: tb/ioseq_core_bench.sv
module ioseq_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int SIDE_W = 2;
  localparam logic [15:0] NOP = 16'hA042;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b1;
  logic        progWe = 1'b0;
  logic [4:0]  progAddr = '0;
  logic [15:0] progData = '0;
  logic [4:0]  wrapTarget = '0;
  logic [4:0]  wrapTop = 5'd31;
  logic [4:0]  inBase = '0;
  logic [4:0]  setBase = '0;
  logic [4:0]  jmpPinSel = 5'd9;
  logic [31:0] gpioIn = '0;
  logic [7:0]  irqFlags = '0;
  logic        osrEmpty = 1'b1;
  logic [4:0]  pc;
  logic        retire;
  logic [31:0] xReg, yReg, gpioOut, gpioDir;
  logic [1:0]  sidePins;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioseq_core #(.PROG_DEPTH(32), .SIDE_W(SIDE_W)) u_ioseq_core (
    .clk(clk), .rstN(rstN), .stall(stall), .progWe(progWe),
    .progAddr(progAddr), .progData(progData), .wrapTarget(wrapTarget),
    .wrapTop(wrapTop), .inBase(inBase), .setBase(setBase),
    .jmpPinSel(jmpPinSel), .gpioIn(gpioIn), .irqFlags(irqFlags),
    .osrEmpty(osrEmpty), .pc(pc), .retire(retire), .xReg(xReg),
    .yReg(yReg), .gpioOut(gpioOut), .gpioDir(gpioDir), .sidePins(sidePins)
  );

  typedef struct packed {
    logic [4:0]  xs;
    logic [4:0]  ys;
    logic [2:0]  cond;
    logic        pin;
    logic        osrE;
    logic        taken;
    logic [31:0] expX;
    logic [31:0] expY;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{5'd3, 5'd0, 3'd0, 1'b0, 1'b1, 1'b1, 32'd3, 32'd0},
    '{5'd0, 5'd0, 3'd1, 1'b0, 1'b1, 1'b1, 32'd0, 32'd0},
    '{5'd5, 5'd0, 3'd1, 1'b0, 1'b1, 1'b0, 32'd5, 32'd0},
    '{5'd0, 5'd0, 3'd2, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'd0},
    '{5'd3, 5'd0, 3'd2, 1'b0, 1'b1, 1'b1, 32'd2, 32'd0},
    '{5'd0, 5'd0, 3'd3, 1'b0, 1'b1, 1'b1, 32'd0, 32'd0},
    '{5'd0, 5'd6, 3'd3, 1'b0, 1'b1, 1'b0, 32'd0, 32'd6},
    '{5'd0, 5'd1, 3'd4, 1'b0, 1'b1, 1'b1, 32'd0, 32'd0},
    '{5'd4, 5'd4, 3'd5, 1'b0, 1'b1, 1'b0, 32'd4, 32'd4},
    '{5'd4, 5'd7, 3'd5, 1'b0, 1'b1, 1'b1, 32'd4, 32'd7},
    '{5'd0, 5'd0, 3'd6, 1'b1, 1'b1, 1'b1, 32'd0, 32'd0},
    '{5'd0, 5'd0, 3'd6, 1'b0, 1'b1, 1'b0, 32'd0, 32'd0},
    '{5'd0, 5'd0, 3'd7, 1'b0, 1'b0, 1'b1, 32'd0, 32'd0},
    '{5'd0, 5'd0, 3'd7, 1'b0, 1'b1, 1'b0, 32'd0, 32'd0}
  };

  function automatic logic [15:0] encSet(input logic [2:0] dest, input logic [4:0] v);
    return {3'd7, 5'd0, dest, v};
  endfunction
  function automatic logic [15:0] encJmp(input logic [2:0] c, input logic [4:0] t);
    return {3'd0, 5'd0, c, t};
  endfunction
  function automatic logic [15:0] encWait(input logic [4:0] f, input logic pol,
                                          input logic [1:0] src, input logic [4:0] idx);
    return {3'd1, f, pol, src, idx};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    progWe = 1'b1; progAddr = a; progData = d;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic startProg();
    rstN = 1'b0; stall = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) wr(5'(i), NOP);
  endtask

  task automatic run();
    rstN = 1'b1;
    @(negedge clk);
    stall = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    check("R1 pc", 32'(pc), 32'd0);
    check("R1 x/y", xReg | yReg, 32'd0);
    check("R1 gpio", gpioOut | gpioDir, 32'd0);
    check("R1 side/retire", {29'd0, sidePins, retire}, 32'd0);

    // table of jump-condition vectors: R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      startProg();
      wr(5'd0, encSet(3'd1, VECS[v].xs));
      wr(5'd1, encSet(3'd2, VECS[v].ys));
      wr(5'd2, encJmp(VECS[v].cond, 5'd20));
      gpioIn = 32'(VECS[v].pin) << 9;
      osrEmpty = VECS[v].osrE;
      run();
      step(3);
      if (VECS[v].cond == 3'd0)
        check("R3 jump pc", 32'(pc), 32'd20);
      else if (VECS[v].cond == 3'd2 || VECS[v].cond == 3'd4)
        check("R5 jump pc", 32'(pc), VECS[v].taken ? 32'd20 : 32'd3);
      else
        check("R4 jump pc", 32'(pc), VECS[v].taken ? 32'd20 : 32'd3);
      check("R5 x after jump", xReg, VECS[v].expX);
      check("R5 y after jump", yReg, VECS[v].expY);
    end
    gpioIn = '0; osrEmpty = 1'b1;

    // R2 zero-cycle wrap, R12 retire
    startProg();
    wrapTarget = 5'd2; wrapTop = 5'd4;
    run();
    step(4);
    check("R2 pc at wrapTop", 32'(pc), 32'd4);
    check("R12 retire on nop", 32'(retire), 32'd1);
    step(1);
    check("R2 wrap to target", 32'(pc), 32'd2);
    step(1);
    check("R2 after wrap", 32'(pc), 32'd3);

    // R3 taken jump at wrapTop overrides wrap
    startProg();
    wr(5'd4, encJmp(3'd0, 5'd7));
    run();
    step(5);
    check("R3 jump beats wrap", 32'(pc), 32'd7);
    wrapTarget = 5'd0; wrapTop = 5'd31;

    // R9 delay and side split, R12 retire low while idle
    startProg();
    wr(5'd0, {3'd5, 5'b10011, 8'h42});
    run();
    step(1);
    check("R9 side value", 32'(sidePins), 32'd2);
    check("R9 pc after issue", 32'(pc), 32'd1);
    check("R12 retire idle", 32'(retire), 32'd0);
    step(2);
    check("R9 side held in idle", 32'(sidePins), 32'd2);
    step(1);
    check("R9 pc after 3 idle", 32'(pc), 32'd1);
    step(1);
    check("R9 next executes", 32'(pc), 32'd2);
    check("R9 next side", 32'(sidePins), 32'd0);

    // R11 stall freezes idle count
    startProg();
    wr(5'd0, {3'd5, 5'b10011, 8'h42});
    run();
    step(1);
    stall = 1'b1;
    step(5);
    check("R11 pc frozen", 32'(pc), 32'd1);
    check("R11 retire low", 32'(retire), 32'd0);
    stall = 1'b0;
    step(3);
    check("R11 idle resumes", 32'(pc), 32'd1);
    step(1);
    check("R11 after idle", 32'(pc), 32'd2);

    // R6/R10 absolute pin wait with side and delay
    startProg();
    wr(5'd0, encWait(5'b01010, 1'b1, 2'd0, 5'd7));
    run();
    step(1);
    check("R10 side during wait", 32'(sidePins), 32'd1);
    check("R6 held", 32'(pc), 32'd0);
    step(2);
    check("R6 still held", 32'(pc), 32'd0);
    gpioIn = 32'h80;
    step(1);
    check("R6 released", 32'(pc), 32'd1);
    step(2);
    check("R10 delay after wait", 32'(pc), 32'd1);
    step(1);
    check("R10 next after delay", 32'(pc), 32'd2);
    gpioIn = '0;

    // R6 relative pin wait, polarity low
    startProg();
    inBase = 5'd30;
    wr(5'd0, encWait(5'd0, 1'b0, 2'd1, 5'd3));
    gpioIn = 32'h2;
    run();
    step(2);
    check("R6 rel held", 32'(pc), 32'd0);
    gpioIn = '0;
    step(1);
    check("R6 rel released", 32'(pc), 32'd1);

    // R6 event flag wait
    startProg();
    wr(5'd0, encWait(5'd0, 1'b1, 2'd2, 5'd5));
    run();
    step(2);
    check("R6 irq held", 32'(pc), 32'd0);
    irqFlags = 8'h20;
    step(1);
    check("R6 irq released", 32'(pc), 32'd1);
    irqFlags = '0;

    // R7 set with rotation, R8 nop and other opcodes, R13 store
    startProg();
    setBase = 5'd30;
    wr(5'd0, encSet(3'd0, 5'b10111));
    wr(5'd1, encSet(3'd4, 5'b00011));
    wr(5'd2, encSet(3'd1, 5'd31));
    wr(5'd3, encSet(3'd2, 5'd17));
    wr(5'd5, 16'h4FFF);
    run();
    step(4);
    check("R7 gpioOut", gpioOut, 32'hC0000005);
    check("R7 gpioDir", gpioDir, 32'hC0000000);
    check("R7 x", xReg, 32'd31);
    check("R13 y from store", yReg, 32'd17);
    step(2);
    check("R8 pc", 32'(pc), 32'd6);
    check("R8 gpio unchanged", gpioOut ^ gpioDir, 32'h00000005);
    check("R8 xy unchanged", xReg + yReg, 32'd48);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule